// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block is the host-side master for a chain of converters. All of them share one conversion-start line and one serial clock. The chain's returned data comes back on a single input line. When a start request is accepted, the controller raises conversion-start, so every device samples at the same instant. It then waits for the conversions to finish. With the fixed-delay option it waits a set number of system cycles. With the busy-flag option it waits until the returned data line goes high.

After the wait, the controller drives conversion-start low and lets half a serial-clock period pass. It then issues one clock pulse per result bit, 18 for each device in the chain. The devices change their output on falling serial-clock edges. The controller captures the returned line at the system-clock edge where the serial clock rises. The bit stream is deserialised into one word per device, in chain order. Each word arrives most significant bit first.

The words are published together with a one-cycle valid pulse. The controller then enforces an acquisition interval before it will begin another conversion. All timing is counted in system-clock cycles and set by parameters.

Top module: `daisy_rdr`

## Requirements
- R1: Every conversion cycle produces exactly WORD_W×N_DEV serial-clock pulses. Each pulse is high for HALF_CYC system cycles and rises 2×HALF_CYC cycles after the previous one.
- R2: With USE_BUSY=0, conversion-start rises on the clock edge after an idle start request is sampled and stays high for exactly CONV_CYC system cycles.
- R3: The serial clock idles low and is never high while conversion-start is high.
- R4: With USE_BUSY=1, conversion-start stays high until the returned data line reads 1, and it falls on the clock edge where that 1 is sampled.
- R5: The returned data line is sampled on the edge where the serial clock rises. Bits are taken MSB first. The first WORD_W bits form word 0 at words_o[WORD_W-1:0], the next WORD_W bits form word 1 above it, and so on.
- R6: valid_o is high for exactly one cycle per conversion. words_o changes only on that edge and holds its value until the next valid pulse.
- R7: busy_o is high whenever conversion-start or the serial clock is high. A start request that arrives while busy_o is high starts no further conversion.
- R8: At least ACQ_CYC+1 cycles separate the valid pulse from the next rise of conversion-start. When start_i is held high, the separation is exactly ACQ_CYC+1 cycles, and busy_o is high during the valid pulse.
- R9: During reset, cnvst_o, sclk_o, valid_o and busy_o are 0, and words_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| sdi_i | input | 1 | Data returned from the device nearest the host |
| cnvst_o | output | 1 | Shared conversion-start line |
| sclk_o | output | 1 | Shared serial clock |
| words_o | output | N_DEV×WORD_W | Result words; word i is at [i×WORD_W +: WORD_W] |
| valid_o | output | 1 | One-cycle pulse when words_o is updated |
| busy_o | output | 1 | A conversion, readout or acquisition interval is in progress |

## Verification
The bench builds two instances side by side, each with a three-device chain, so every conversion cycle is a burst of 54 pulses. One instance uses the fixed 20-cycle wait with a half period of 2. The other uses the busy flag with a half period of 3. This covers both ways of gating readout, even and odd pacing, and the one-cycle spacing between a device's falling-edge update and the host's rising-edge sample. A 5-cycle acquisition interval is short enough that back-to-back conversions with start held high measure the exact gap. Start requests are also injected during the conversion phase and during readout.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SETTLE,
        ST_HIGH,
        ST_LOW,
        ST_ACQ
    } rdr_state_e;
endpackage

// File: rtl/rdr_timer.sv
module rdr_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign zero_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (!zero_o)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Phase lengths of the serial clock depend on a steady one-per-cycle count (R1)
    p_timer_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("timer did not step down");
endmodule

// File: rtl/rdr_deser.sv
module rdr_deser #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en_i,
    input  logic                    bit_i,
    input  logic                    capture_i,
    output logic [N_DEV*WORD_W-1:0] words_o
);
    localparam int TOTAL = N_DEV * WORD_W;

    logic [TOTAL-1:0] sr_d, sr_q;
    logic [TOTAL-1:0] out_d, out_q;
    logic [TOTAL-1:0] reordered;

    // The first bits received land at the top of the shift register and belong to word 0
    for (genvar i = 0; i < N_DEV; i++) begin : g_word
        assign reordered[i*WORD_W +: WORD_W] = sr_q[TOTAL-1-i*WORD_W -: WORD_W];
    end

    always_comb begin
        sr_d  = sr_q;
        out_d = out_q;
        if (shift_en_i)
            sr_d = {sr_q[TOTAL-2:0], bit_i};
        if (capture_i)
            out_d = reordered;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            out_q <= '0;
        end else begin
            sr_q  <= sr_d;
            out_q <= out_d;
        end
    end

    assign words_o = out_q;

    p_words_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(words_o))
        else $error("result words changed without a capture");
endmodule

// File: rtl/daisy_rdr.sv
module daisy_rdr #(
    parameter int N_DEV    = 3,
    parameter int WORD_W   = 18,
    parameter int HALF_CYC = 2,
    parameter int CONV_CYC = 20,
    parameter int ACQ_CYC  = 5,
    parameter bit USE_BUSY = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    sdi_i,
    output logic                    cnvst_o,
    output logic                    sclk_o,
    output logic [N_DEV*WORD_W-1:0] words_o,
    output logic                    valid_o,
    output logic                    busy_o
);
    import rdr_pkg::*;

    localparam int TOTAL = N_DEV * WORD_W;
    localparam int BIT_W = $clog2(TOTAL + 1);
    localparam int TMAX0 = (HALF_CYC > CONV_CYC) ? HALF_CYC : CONV_CYC;
    localparam int TMAX  = (TMAX0 > ACQ_CYC) ? TMAX0 : ACQ_CYC;
    localparam int TIM_W = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

    typedef struct packed {
        rdr_state_e       st;
        logic             cnvst;
        logic             sclk;
        logic [BIT_W-1:0] bits;
        logic             valid;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             t_load;
    logic [TIM_W-1:0] t_val;
    logic             t_zero;
    logic             shift_en;
    logic             capture;
    logic             conv_done;

    rdr_timer #(.W(TIM_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    rdr_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W)) deser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .bit_i      (sdi_i),
        .capture_i  (capture),
        .words_o    (words_o)
    );

    // Select how the end of conversion is detected
    if (USE_BUSY) begin : g_busy
        assign conv_done = sdi_i;
    end else begin : g_fixed
        assign conv_done = t_zero;
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        t_load      = 1'b0;
        t_val       = '0;
        shift_en    = 1'b0;
        capture     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_CONV;
                    ctl_d.cnvst = 1'b1;
                    t_load      = 1'b1;
                    t_val       = TIM_W'(CONV_CYC - 1);
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    ctl_d.st    = ST_SETTLE;
                    ctl_d.cnvst = 1'b0;
                    t_load      = 1'b1;
                    t_val       = TIM_W'(HALF_CYC - 1);
                end
            end
            ST_SETTLE, ST_LOW: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (ctl_q.bits == BIT_W'(TOTAL)) begin
                        ctl_d.st    = ST_ACQ;
                        ctl_d.valid = 1'b1;
                        ctl_d.bits  = '0;
                        capture     = 1'b1;
                        t_val       = TIM_W'(ACQ_CYC - 1);
                    end else begin
                        ctl_d.st   = ST_HIGH;
                        ctl_d.sclk = 1'b1;
                        ctl_d.bits = ctl_q.bits + 1'b1;
                        shift_en   = 1'b1;
                        t_val      = TIM_W'(HALF_CYC - 1);
                    end
                end
            end
            ST_HIGH: begin
                if (t_zero) begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.sclk = 1'b0;
                    t_load     = 1'b1;
                    t_val      = TIM_W'(HALF_CYC - 1);
                end
            end
            ST_ACQ: begin
                if (t_zero)
                    ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnvst: 1'b0, sclk: 1'b0, bits: '0, valid: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnvst_o = ctl_q.cnvst;
    assign sclk_o  = ctl_q.sclk;
    assign valid_o = ctl_q.valid;
    assign busy_o  = (ctl_q.st != ST_IDLE);

    p_clk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cnvst_o)
        else $error("serial clock high while conversion-start high");

    p_bit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.bits <= BIT_W'(TOTAL))
        else $error("pulse count beyond chain length");

    p_busy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst_o) |-> (!USE_BUSY || $past(sdi_i)))
        else $error("readout began before completion flag");

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("valid longer than one cycle");

    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnvst_o) |-> $past(!busy_o))
        else $error("conversion started while busy");

    p_acq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o)
        else $error("acquisition interval not covered by busy");
endmodule

// File: tb/daisy_rdr_tb_top.sv
module chain_dev_model #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 18,
    parameter int HALF   = 2,
    parameter int MC     = 12,
    parameter bit BUSY   = 1'b0
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic                    cnvst,
    input  logic                    sclk,
    input  logic                    valid,
    input  logic                    busy,
    input  logic [N_DEV*WORD_W-1:0] words,
    output logic                    dout
);
    localparam int TOT = N_DEV * WORD_W;

    logic [TOT-1:0] sr = '0;
    logic conv = 1'b0, cnvst_q = 1'b0, sclk_q = 1'b0;
    int   cnt = 0;
    logic conv_act;

    always @(posedge clk) begin
        cnvst_q <= cnvst;
        sclk_q  <= sclk;
        if (cnvst && !cnvst_q) begin
            sr   <= words;
            conv <= 1'b1;
            cnt  <= 0;
        end else begin
            if (conv) begin
                if (cnt == MC - 1) conv <= 1'b0;
                else               cnt  <= cnt + 1;
            end
            if (sclk_q && !sclk) sr <= {sr[TOT-2:0], 1'b0};
        end
    end

    assign conv_act = conv | (cnvst & ~cnvst_q);
    assign dout = BUSY ? (conv_act ? 1'b0 : (cnvst ? 1'b1 : sr[TOT-1])) : sr[TOT-1];

    int n_rise = 0, n_cnv = 0, n_valid = 0, cnv_len = 0, last_gap = 0;
    int bad_hi = 0, bad_int = 0, bad_overlap = 0, bad_valid = 0, bad_busy = 0;
    int cyc = 0, hi_run = 0, last_rise = 0, rises_conv = 0, cnv_start = 0, valid_cyc = 0;
    bit have_valid = 0;
    logic cnvst_p = 0, sclk_p = 0, valid_p = 0;

    always @(negedge clk) begin
        cyc++;
        if (clr) begin
            n_rise = 0; n_cnv = 0; n_valid = 0; cnv_len = 0; last_gap = 0;
            bad_hi = 0; bad_int = 0; bad_overlap = 0; bad_valid = 0; bad_busy = 0;
            hi_run = 0; rises_conv = 0; have_valid = 0;
        end else begin
            if (sclk && !sclk_p) begin
                n_rise++;
                if (rises_conv > 0 && (cyc - last_rise) != 2 * HALF) bad_int++;
                last_rise = cyc;
                rises_conv++;
            end
            if (sclk) hi_run++;
            else if (sclk_p) begin
                if (hi_run != HALF) bad_hi++;
                hi_run = 0;
            end
            if (cnvst && !cnvst_p) begin
                n_cnv++;
                cnv_start  = cyc;
                rises_conv = 0;
                if (have_valid) last_gap = cyc - valid_cyc;
            end
            if (!cnvst && cnvst_p) cnv_len = cyc - cnv_start;
            if (sclk && cnvst) bad_overlap++;
            if (valid) begin
                n_valid++;
                valid_cyc  = cyc;
                have_valid = 1;
                if (valid_p) bad_valid++;
            end
            if ((cnvst || sclk) && !busy) bad_busy++;
        end
        cnvst_p = cnvst;
        sclk_p  = sclk;
        valid_p = valid;
    end
endmodule

module daisy_rdr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEV      = 3;
    localparam int WORD_W     = 18;
    localparam int TOT        = N_DEV * WORD_W;
    localparam int CONV_CYC   = 20;
    localparam int ACQ_CYC    = 5;
    localparam int MODEL_CONV = 12;
    localparam int HALF_A     = 2;
    localparam int HALF_B     = 3;

    logic clk = 0, rst_n = 0, clr = 0, start_a = 0, start_b = 0;
    logic sdi_a, sdi_b, cnvst_a, cnvst_b, sclk_a, sclk_b;
    logic valid_a, valid_b, busy_a, busy_b;
    logic [TOT-1:0] words_a, words_b;
    logic [TOT-1:0] mw_a = '0, mw_b = '0;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    daisy_rdr #(.N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_CYC(HALF_A), .CONV_CYC(CONV_CYC),
                .ACQ_CYC(ACQ_CYC), .USE_BUSY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .sdi_i(sdi_a), .cnvst_o(cnvst_a),
        .sclk_o(sclk_a), .words_o(words_a), .valid_o(valid_a), .busy_o(busy_a));

    daisy_rdr #(.N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_CYC(HALF_B), .CONV_CYC(CONV_CYC),
                .ACQ_CYC(ACQ_CYC), .USE_BUSY(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .sdi_i(sdi_b), .cnvst_o(cnvst_b),
        .sclk_o(sclk_b), .words_o(words_b), .valid_o(valid_b), .busy_o(busy_b));

    chain_dev_model #(.N_DEV(N_DEV), .WORD_W(WORD_W), .HALF(HALF_A), .MC(MODEL_CONV), .BUSY(1'b0)) mdl_a (
        .clk(clk), .clr(clr), .cnvst(cnvst_a), .sclk(sclk_a), .valid(valid_a), .busy(busy_a),
        .words(mw_a), .dout(sdi_a));

    chain_dev_model #(.N_DEV(N_DEV), .WORD_W(WORD_W), .HALF(HALF_B), .MC(MODEL_CONV), .BUSY(1'b1)) mdl_b (
        .clk(clk), .clr(clr), .cnvst(cnvst_b), .sclk(sclk_b), .valid(valid_b), .busy(busy_b),
        .words(mw_b), .dout(sdi_b));

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [TOT-1:0] exp_vec(input logic [17:0] w0, w1, w2);
        return {w2, w1, w0};
    endfunction

    task automatic test_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "cnvst in reset", {63'd0, cnvst_a | cnvst_b}, 64'd0);
        chk("R9", "sclk in reset",  {63'd0, sclk_a | sclk_b}, 64'd0);
        chk("R9", "valid in reset", {63'd0, valid_a | valid_b}, 64'd0);
        chk("R9", "busy in reset",  {63'd0, busy_a | busy_b}, 64'd0);
        chk("R9", "words in reset", {10'd0, words_a | words_b}, 64'd0);
    endtask

    // One conversion on instance a (b=0, fixed wait) or b (b=1, busy flag).
    // poke>=0: extra start requests during conversion and at serial pulse number poke (R7).
    task automatic run_conv(input bit b, input logic [17:0] w0, w1, w2, input int poke);
        if (b) mw_b = {w0, w1, w2}; else mw_a = {w0, w1, w2};
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        if (b) start_b = 1; else start_a = 1;
        @(negedge clk);
        start_a = 0; start_b = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (!b && poke >= 0)
                start_a = (i == 2) || (mdl_a.n_rise == poke);
            if ((b ? mdl_b.n_valid : mdl_a.n_valid) > 0) break;
        end
        start_a = 0;
        repeat (ACQ_CYC + 4) @(negedge clk);
        #1;
        if (b) begin
            chk("R1", "pulse count", 64'(mdl_b.n_rise), 64'(TOT));
            chk("R1", "high width errors", 64'(mdl_b.bad_hi), 64'd0);
            chk("R1", "pulse spacing errors", 64'(mdl_b.bad_int), 64'd0);
            chk("R3", "overlap count", 64'(mdl_b.bad_overlap), 64'd0);
            chk("R4", "start high length", 64'(mdl_b.cnv_len), 64'(MODEL_CONV + 2));
            chk("R5", "words", {10'd0, words_b}, {10'd0, exp_vec(w0, w1, w2)});
            chk("R6", "valid pulses", 64'(mdl_b.n_valid), 64'd1);
            chk("R6", "valid width errors", 64'(mdl_b.bad_valid), 64'd0);
            chk("R7", "busy gaps", 64'(mdl_b.bad_busy), 64'd0);
        end else begin
            chk("R1", "pulse count", 64'(mdl_a.n_rise), 64'(TOT));
            chk("R1", "high width errors", 64'(mdl_a.bad_hi), 64'd0);
            chk("R1", "pulse spacing errors", 64'(mdl_a.bad_int), 64'd0);
            chk("R3", "overlap count", 64'(mdl_a.bad_overlap), 64'd0);
            chk("R2", "start high length", 64'(mdl_a.cnv_len), 64'(CONV_CYC));
            chk("R5", "words", {10'd0, words_a}, {10'd0, exp_vec(w0, w1, w2)});
            chk("R6", "valid pulses", 64'(mdl_a.n_valid), 64'd1);
            chk("R6", "valid width errors", 64'(mdl_a.bad_valid), 64'd0);
            chk("R7", "busy gaps", 64'(mdl_a.bad_busy), 64'd0);
            chk("R7", "conversions started", 64'(mdl_a.n_cnv), 64'd1);
        end
    endtask

    task automatic test_fixed_basic();
        run_conv(1'b0, 18'h3A5C1, 18'h0F0F0, 18'h20001, -1);
    endtask

    task automatic test_busy_basic();
        run_conv(1'b1, 18'h12345, 18'h2BCDE, 18'h00F3C, -1);
    endtask

    task automatic test_patterns();
        run_conv(1'b0, 18'h3FFFF, 18'h00000, 18'h3FFFF, -1);
        run_conv(1'b1, 18'h00001, 18'h20000, 18'h15555, -1);
        run_conv(1'b1, 18'h2AAAA, 18'h3FFFF, 18'h00000, -1);
    endtask

    task automatic test_hold_other();
        logic [TOT-1:0] keep;
        run_conv(1'b0, 18'h1C0DE, 18'h2F00D, 18'h0BEEF, -1);
        keep = words_a;
        run_conv(1'b1, 18'h3C3C3, 18'h0C3C3, 18'h33333, -1);
        chk("R6", "idle words held", {10'd0, words_a}, {10'd0, keep});
    endtask

    task automatic test_ignore_start();
        run_conv(1'b0, 18'h24680, 18'h13579, 18'h3ACE1, 10);
    endtask

    task automatic test_back_to_back();
        mw_a = {18'h11111, 18'h22222, 18'h33333};
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0; start_a = 1;
        for (int i = 0; i < 3000 && mdl_a.n_rise == 0; i++) begin @(negedge clk); #1; end
        mw_a = {18'h0ABCD, 18'h1DCBA, 18'h2F0F0};
        for (int i = 0; i < 3000 && mdl_a.n_cnv < 2; i++) begin @(negedge clk); #1; end
        start_a = 0;
        for (int i = 0; i < 3000 && mdl_a.n_valid < 2; i++) begin @(negedge clk); #1; end
        repeat (ACQ_CYC + 4) @(negedge clk);
        #1;
        chk("R8", "valid to restart gap", 64'(mdl_a.last_gap), 64'(ACQ_CYC + 1));
        chk("R8", "conversions", 64'(mdl_a.n_cnv), 64'd2);
        chk("R6", "valid pulses", 64'(mdl_a.n_valid), 64'd2);
        chk("R5", "second words", {10'd0, words_a},
            {10'd0, exp_vec(18'h0ABCD, 18'h1DCBA, 18'h2F0F0)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        test_fixed_basic();
        test_busy_basic();
        test_patterns();
        test_hold_other();
        test_ignore_start();
        test_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule